// File: doc/BRIEF.md
# PLL Startup Boost Controller

This block speeds up the first lock of a phase-locked loop. It runs in the clock domain of the divided oscillator input. It watches the up and down correction pulses from the phase detector and compares each pulse against a 64-cycle timing window. The window is centred on the falling edge of the feedback divider output. While boost is active, the block drives a three-state output hard high for upward corrections and hard low for downward ones. This charges or discharges the loop filter much faster than the normal charge pump can.

Boost is a one-shot. The first correction pulse whose high cycles all fall inside the window shows that the loop is close to lock. From the next cycle the output is released and boost stays off. It stays off even if lock is later lost or the dividers are reprogrammed. It is armed again only by a new start of the run control. With the run control low (standby), the output is released and the window and pulse tracking are cleared.

The divider supplies a one-cycle near-terminal-count strobe, `near_tc`. This strobe arrives 32 input-clock periods before the falling edge of the divider output. The window opens on the cycle after the strobe is sampled and stays open for 64 cycles. The state machine has five states:

- BST_OFF: idle or standby, output released.
- BST_ARMED: active, no correction seen yet, output released.
- BST_PUSH_UP: driving high.
- BST_PUSH_DN: driving low.
- BST_DONE: boost finished, output released.

The transitions are:

- arm: BST_OFF to BST_ARMED when the run control is high and was low (or in reset) on the previous cycle.
- push_up: any active state to BST_PUSH_UP when `corr_up` is high.
- push_dn: any active state to BST_PUSH_DN when `corr_dn` is high and `corr_up` is low.
- hold: an active state keeps its direction while no correction is present.
- settle: any active state to BST_DONE on the cycle after a fitting pulse ends.
- standby: every state to BST_OFF whenever the run control is low.

Top module: `boost_ctrl`

## Requirements
- R1: While `rst_n` is low, `boost_oe` and `boost_active` are 0.
- R2: A cycle where `run_en` is sampled high after being low (or after reset) makes `boost_active` 1 on the next cycle, with `boost_oe` still 0 until a correction is seen.
- R3: After `near_tc` is sampled high while the window is closed, the window is open for exactly the 64 following cycles. A `near_tc` sampled while the window is already open is ignored.
- R4: While active, a cycle with `corr_up` high gives `boost_oe`=1 and `boost_val`=1 on the next cycle. The drive is held through cycles without a correction.
- R5: While active, a cycle with `corr_dn` high and `corr_up` low gives `boost_oe`=1 and `boost_val`=0 on the next cycle. When both are high, up wins.
- R6: A correction pulse is the run of cycles in which `corr_up` or `corr_dn` is high. If every high cycle of the pulse falls in an open window, then on the cycle after its first low cycle `boost_active` and `boost_oe` are 0.
- R7: A pulse that starts before the window opens, or is still high after it closes, does not end boost.
- R8: Once boost has ended and `run_en` stays high, corrections and `near_tc` have no effect: `boost_oe` and `boost_active` stay 0.
- R9: `run_en` sampled low gives `boost_oe`=0 and `boost_active`=0 on the next cycle and clears the window. A later rising `run_en` re-arms boost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator input clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| run_en | input | 1 | Run control; low selects standby |
| near_tc | input | 1 | One-cycle strobe, 32 cycles before divider output falls |
| corr_up | input | 1 | Phase detector upward correction pulse |
| corr_dn | input | 1 | Phase detector downward correction pulse |
| boost_oe | output | 1 | Boost output driver enable (0 = high impedance) |
| boost_val | output | 1 | Boost drive level, valid when `boost_oe` is 1 |
| boost_active | output | 1 | Boost is armed and not yet finished |

## Verification
The hardest cases to reach are the window edges. A pulse that occupies only the 64th open cycle must end boost. A pulse that first rises on the 65th cycle, or that starts on the 63rd and runs past the close, must not.

The stimulus counts exact cycles from a single `near_tc` strobe to place each pulse on these edges. It also re-strobes mid-window to show that the second strobe does not stretch the window. A behavioural model built on counters is compared against all three outputs on every clock. Directed checks follow, and then a long pseudo-random phase with occasional standby entries to reach re-arming paths.

// File: rtl/boost_pkg.sv
`timescale 1ns/1ps
package boost_pkg;
    typedef enum logic [2:0] {
        BST_OFF     = 3'd0,
        BST_ARMED   = 3'd1,
        BST_PUSH_UP = 3'd2,
        BST_PUSH_DN = 3'd3,
        BST_DONE    = 3'd4
    } bst_state_e;
endpackage

// File: rtl/boost_window.sv
`timescale 1ns/1ps
// Active-low lock window: opens the cycle after near_tc is sampled with the
// window closed and stays open for 2*HALF_WIN cycles (R3).
module boost_window #(
    parameter int HALF_WIN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic near_tc,
    output logic win_n
);
    localparam int WIN_LEN = 2 * HALF_WIN;
    localparam int CNT_W   = $clog2(WIN_LEN + 1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (!run_en) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else if (near_tc) begin
            left_q <= CNT_W'(WIN_LEN);
        end
    end

    assign win_n = (left_q == '0);
endmodule

// File: rtl/boost_pulse_track.sv
`timescale 1ns/1ps
// Follows each correction pulse and flags, on its first low cycle, whether
// every high cycle of it saw the window open (R6, R7).
module boost_pulse_track (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic corr_up,
    input  logic corr_dn,
    input  logic win_n,
    output logic fit
);
    logic corr;
    logic corr_d;
    logic inside_q;
    logic inside_nx;

    assign corr = corr_up | corr_dn;

    always_comb begin
        inside_nx = inside_q;
        if (corr) begin
            inside_nx = (corr_d ? inside_q : 1'b1) & ~win_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_d   <= 1'b0;
            inside_q <= 1'b0;
        end else if (!run_en) begin
            corr_d   <= 1'b0;
            inside_q <= 1'b0;
        end else begin
            corr_d   <= corr;
            inside_q <= inside_nx;
        end
    end

    assign fit = run_en & ~corr & corr_d & inside_q;
endmodule

// File: rtl/boost_fsm.sv
`timescale 1ns/1ps
module boost_fsm
    import boost_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic corr_up,
    input  logic corr_dn,
    input  logic fit,
    output logic boost_oe,
    output logic boost_val,
    output logic boost_active
);
    bst_state_e state_q;
    bst_state_e state_nx;
    logic       run_d;

    always_comb begin
        state_nx = state_q;
        if (!run_en) begin
            state_nx = BST_OFF;                         // standby
        end else begin
            unique case (state_q)
                BST_OFF: begin
                    if (!run_d) state_nx = BST_ARMED;   // arm
                end
                BST_ARMED, BST_PUSH_UP, BST_PUSH_DN: begin
                    if (fit)          state_nx = BST_DONE;     // settle
                    else if (corr_up) state_nx = BST_PUSH_UP;  // push_up
                    else if (corr_dn) state_nx = BST_PUSH_DN;  // push_dn
                end
                BST_DONE: state_nx = BST_DONE;
                default:  state_nx = BST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BST_OFF;
            run_d   <= 1'b0;
        end else begin
            state_q <= state_nx;
            run_d   <= run_en;
        end
    end

    always_comb begin
        boost_oe     = 1'b0;
        boost_val    = 1'b0;
        boost_active = 1'b0;
        unique case (state_q)
            BST_OFF, BST_DONE: ;
            BST_ARMED: boost_active = 1'b1;
            BST_PUSH_UP: begin
                boost_active = 1'b1;
                boost_oe     = 1'b1;
                boost_val    = 1'b1;
            end
            BST_PUSH_DN: begin
                boost_active = 1'b1;
                boost_oe     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/boost_ctrl.sv
`timescale 1ns/1ps
module boost_ctrl #(
    parameter int HALF_WIN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic near_tc,
    input  logic corr_up,
    input  logic corr_dn,
    output logic boost_oe,
    output logic boost_val,
    output logic boost_active
);
    logic win_n;
    logic fit;

    boost_window #(.HALF_WIN(HALF_WIN)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .near_tc (near_tc),
        .win_n   (win_n)
    );

    boost_pulse_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .corr_up (corr_up),
        .corr_dn (corr_dn),
        .win_n   (win_n),
        .fit     (fit)
    );

    boost_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .corr_up      (corr_up),
        .corr_dn      (corr_dn),
        .fit          (fit),
        .boost_oe     (boost_oe),
        .boost_val    (boost_val),
        .boost_active (boost_active)
    );
endmodule

// File: rtl/boost_ctrl_chk.sv
`timescale 1ns/1ps
module boost_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic corr_up,
    input logic corr_dn,
    input logic boost_oe,
    input logic boost_val,
    input logic boost_active
);
    logic run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_en;
    end

    // R9
    standby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!boost_oe && !boost_active));

    // R2
    arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !run_q) |=> boost_active);

    // R4
    drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_active && run_en && corr_up) |=> (boost_oe && boost_val));

    // R5
    drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_active && run_en && corr_dn && !corr_up) |=> (boost_oe && !boost_val));

    // R8
    stay_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && run_q && !boost_active) |=> !boost_active);

    // R6
    drive_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boost_oe |-> boost_active);

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!boost_oe && !boost_active);
        end
    end
endmodule

bind boost_ctrl boost_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .corr_up      (corr_up),
    .corr_dn      (corr_dn),
    .boost_oe     (boost_oe),
    .boost_val    (boost_val),
    .boost_active (boost_active)
);

// File: tb/test_boost_ctrl.sv
`timescale 1ns/1ps
module test_boost_ctrl;
    localparam int WIN = 64;

    logic clk = 1'b0;
    logic rst_n, run_en, near_tc, corr_up, corr_dn;
    logic boost_oe, boost_val, boost_active;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;

    always #4 clk = ~clk;

    boost_ctrl i_boost_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .near_tc(near_tc),
        .corr_up(corr_up), .corr_dn(corr_dn),
        .boost_oe(boost_oe), .boost_val(boost_val), .boost_active(boost_active)
    );

    // Behavioural reference: 0 off, 1 armed, 2 up, 3 down, 4 finished
    int m_mode, m_left;
    bit m_ok, m_prev_corr, m_prev_run;

    always @(posedge clk) begin
        bit c, open, good;
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_ok = 0; m_prev_corr = 0; m_prev_run = 0;
        end else begin
            c    = corr_up | corr_dn;
            open = (m_left > 0);
            good = run_en && !c && m_prev_corr && m_ok;
            if (!run_en) m_mode = 0;
            else if (m_mode == 0) begin
                if (!m_prev_run) m_mode = 1;
            end else if (m_mode != 4) begin
                if (good) m_mode = 4;
                else if (corr_up) m_mode = 2;
                else if (corr_dn) m_mode = 3;
            end
            if (!run_en) begin
                m_left = 0; m_ok = 0; m_prev_corr = 0;
            end else begin
                if (c) m_ok = (m_prev_corr ? m_ok : 1'b1) && open;
                m_prev_corr = c;
                if (m_left > 0) m_left = m_left - 1;
                else if (near_tc) m_left = WIN;
            end
            m_prev_run = run_en;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 model boost_oe", boost_oe, (m_mode == 2 || m_mode == 3));
            chk("R5 model boost_val", boost_val, (m_mode == 2));
            chk("R6 model boost_active", boost_active, (m_mode >= 1 && m_mode <= 3));
        end
    end

    task automatic tick(input logic u, input logic d, input logic n);
        corr_up = u; corr_dn = d; near_tc = n;
        @(negedge clk);
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) tick(0, 0, 0);
    endtask

    task automatic report;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        report();
    end

    initial begin
        rst_n = 0; run_en = 0; corr_up = 0; corr_dn = 0; near_tc = 0;
        repeat (3) @(negedge clk);
        chk("R1 boost_oe in reset", boost_oe, 1'b0);
        chk("R1 boost_active in reset", boost_active, 1'b0);
        rst_n = 1;
        idle(3);
        chk("R9 idle while run low", boost_active, 1'b0);

        run_en = 1;
        tick(0, 0, 0);
        chk("R2 armed", boost_active, 1'b1);
        chk("R2 released when armed", boost_oe, 1'b0);

        tick(1, 0, 0);
        chk("R4 up drive oe", boost_oe, 1'b1);
        chk("R4 up drive val", boost_val, 1'b1);
        tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R7 no window keeps boost", boost_active, 1'b1);
        chk("R4 drive held", boost_val, 1'b1);
        tick(0, 1, 0);
        chk("R5 down drive oe", boost_oe, 1'b1);
        chk("R5 down drive val", boost_val, 1'b0);
        tick(1, 1, 0);
        chk("R5 up priority", boost_val, 1'b1);
        tick(0, 0, 0);

        // pulse runs past window close
        tick(0, 0, 1);
        idle(62);
        tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R7 overrun keeps boost", boost_active, 1'b1);

        // pulse starts before window opens
        tick(1, 0, 1);
        tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R7 early start keeps boost", boost_active, 1'b1);
        idle(70);

        // pulse on first cycle after window
        tick(0, 0, 1);
        idle(64);
        tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R3 cycle 65 outside window", boost_active, 1'b1);

        // retrigger inside window is ignored
        tick(0, 0, 1);
        idle(29);
        tick(0, 0, 1);
        idle(39);
        tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R3 retrigger ignored", boost_active, 1'b1);
        idle(10);

        // pulse on last window cycle fits
        tick(0, 0, 1);
        idle(63);
        tick(0, 1, 0);
        chk("R5 down during fit pulse", boost_val, 1'b0);
        tick(0, 0, 0);
        chk("R6 fit ends boost active", boost_active, 1'b0);
        chk("R6 fit releases output", boost_oe, 1'b0);

        // finished: no further effect
        tick(1, 0, 0);
        chk("R8 up after done", boost_oe, 1'b0);
        tick(0, 0, 1);
        idle(3);
        tick(0, 1, 0); tick(0, 1, 0);
        tick(0, 0, 0);
        chk("R8 stays done oe", boost_oe, 1'b0);
        chk("R8 stays done active", boost_active, 1'b0);

        // standby and re-arm
        run_en = 0;
        tick(0, 0, 0);
        chk("R9 standby inactive", boost_active, 1'b0);
        run_en = 1;
        tick(0, 0, 0);
        chk("R9 re-armed", boost_active, 1'b1);
        tick(0, 1, 0);
        chk("R5 down after re-arm", boost_oe, 1'b1);
        run_en = 0;
        tick(0, 1, 0);
        chk("R9 standby releases drive", boost_oe, 1'b0);
        chk("R9 standby clears active", boost_active, 1'b0);

        // mid-window multi-cycle pulse fits
        run_en = 1;
        tick(0, 0, 0);
        tick(0, 0, 1);
        idle(5);
        tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R6 mid-window fit", boost_active, 1'b0);

        // pseudo-random sweep against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 1000;
            if (r < 3) run_en = ~run_en;
            tick(($urandom % 16) == 0, ($urandom % 20) == 0, ($urandom % 90) == 0);
        end
        idle(2);
        report();
    end
endmodule